// File: doc/BRIEF.md
# Address-latched cartridge bank mapper

This block maps a small cartridge's ROMs into an 8-bit console's CPU and picture-processor address spaces. The CPU's upper 32 KB is split into two 16 KB windows. The lower window ($8000-$BFFF) shows a switchable program ROM bank. The upper window ($C000-$FFFF) always shows the last program bank. The picture processor's 8 KB pattern space ($0000-$1FFF) shows one switchable character ROM bank.

Bank selection happens on a CPU write anywhere at or above $8000. On that write the block captures the four lowest address lines into a bank register. The data bus is not connected, so a write never causes a bus conflict. Writes below $8000, including those software issues to $6000, leave the mapper untouched.

Nametable mirroring is fixed by a static strap input and steers the console-RAM address line 10.

Top module: `addr_latch_mapper`

## Requirements
- R1: While reset is asserted and after it is released, the bank register holds zero: both the program bank field and the character bank field read 0.
- R2: On the rising clock edge where `cpu_wr` is 1 and `cpu_addr[15]` is 1, the program bank field takes `cpu_addr[3:2]` and the character bank field takes `cpu_addr[1:0]`. Address bits [14:4] do not affect the captured value. The new banks are visible from the cycle after that edge.
- R3: When `cpu_addr[14]` is 0, `prg_addr` is {program bank field, `cpu_addr[13:0]`}.
- R4: When `cpu_addr[14]` is 1, `prg_addr[15:14]` is 3 (the last 16 KB bank) whatever the register holds, and `prg_addr[13:0]` equals `cpu_addr[13:0]`.
- R5: A write with `cpu_addr[15]` equal to 0 changes neither bank field. This includes every write to $6000-$7FFF. Cycles without a write also leave both fields unchanged.
- R6: `prg_ce` is 1 exactly when `cpu_rd` is 1 and `cpu_addr[15]` is 1.
- R7: `chr_addr` is {character bank field, `ppu_addr[12:0]`}.
- R8: `ciram_a10` equals `ppu_addr[10]` when `mirror_vert` is 1 (vertical mirroring) and `ppu_addr[11]` when `mirror_vert` is 0 (horizontal mirroring).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe, high for one clock per write |
| ppu_addr | input | 13 | Picture-processor address lines A12..A0 |
| mirror_vert | input | 1 | Mirroring strap: 1 vertical, 0 horizontal |
| prg_addr | output | 16 | Program ROM address |
| prg_ce | output | 1 | Program ROM chip enable |
| chr_addr | output | 15 | Character ROM address |
| ciram_a10 | output | 1 | Console nametable RAM address line 10 |

## Verification
Every cycle, the bound checker confirms four things:
- the register capture on a qualified write, for both fields;
- that both fields hold on all other cycles;
- that the upper window is pinned to bank 3 while the lower window follows the register;
- that the chip enable, the character address and the mirroring line agree with their inputs.

Some behaviours only the bench scenarios can show:
- the zero state during and just after reset;
- that upper address bits and writes to $6000 leave the banks alone, through the read-back that follows;
- agreement with the bench's reference model over long random mixes of reads, writes, strap values and addresses.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int PRG_SEL_W = 2;
    localparam int CHR_SEL_W = 2;
    localparam int SEL_W     = PRG_SEL_W + CHR_SEL_W;

    // prg field occupies the upper bits so a cast from the low address bits
    // places A3..A2 in prg and A1..A0 in chr
    typedef struct packed {
        logic [PRG_SEL_W-1:0] prg;
        logic [CHR_SEL_W-1:0] chr;
    } bank_sel_t;
endpackage

// File: rtl/mapper_bank_latch.sv
module mapper_bank_latch
    import mapper_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] addr_lo,
    output bank_sel_t        sel_q
);
    typedef struct packed {
        bank_sel_t sel;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.sel = bank_sel_t'(addr_lo);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q = st_q.sel;
endmodule

// File: rtl/mapper_prg_map.sv
module mapper_prg_map
    import mapper_pkg::*;
#(
    parameter int WIN_AW = 14
) (
    input  logic                        upper_win,
    input  logic [WIN_AW-1:0]           offset,
    input  logic [PRG_SEL_W-1:0]        bank_sel,
    output logic [WIN_AW+PRG_SEL_W-1:0] rom_addr
);
    localparam logic [PRG_SEL_W-1:0] LAST_BANK = '1;

    logic [PRG_SEL_W-1:0] bank_d;

    always_comb begin
        bank_d   = upper_win ? LAST_BANK : bank_sel;
        rom_addr = {bank_d, offset};
    end
endmodule

// File: rtl/mapper_chr_map.sv
module mapper_chr_map
    import mapper_pkg::*;
#(
    parameter int WIN_AW = 13
) (
    input  logic [WIN_AW-1:0]           ppu_off,
    input  logic [CHR_SEL_W-1:0]        bank_sel,
    input  logic                        mirror_vert,
    output logic [WIN_AW+CHR_SEL_W-1:0] rom_addr,
    output logic                        nt_a10
);
    always_comb begin
        rom_addr = {bank_sel, ppu_off};
        nt_a10   = mirror_vert ? ppu_off[10] : ppu_off[11];
    end
endmodule

// File: rtl/addr_latch_mapper.sv
module addr_latch_mapper
    import mapper_pkg::*;
#(
    parameter int CPU_AW     = 16,
    parameter int PRG_WIN_AW = 14,
    parameter int CHR_WIN_AW = 13,
    localparam int PRG_AW    = PRG_WIN_AW + PRG_SEL_W,
    localparam int CHR_AW    = CHR_WIN_AW + CHR_SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic                  cpu_rd,
    input  logic                  cpu_wr,
    input  logic [CHR_WIN_AW-1:0] ppu_addr,
    input  logic                  mirror_vert,
    output logic [PRG_AW-1:0]     prg_addr,
    output logic                  prg_ce,
    output logic [CHR_AW-1:0]     chr_addr,
    output logic                  ciram_a10
);
    logic                 rom_space;
    logic                 wr_en;
    bank_sel_t            bank_q;
    logic [PRG_SEL_W-1:0] prg_sel;

    assign rom_space = cpu_addr[CPU_AW-1];
    assign wr_en     = cpu_wr & rom_space;
    assign prg_ce    = cpu_rd & rom_space;
    assign prg_sel   = bank_q.prg;

    mapper_bank_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr_lo (cpu_addr[SEL_W-1:0]),
        .sel_q   (bank_q)
    );

    mapper_prg_map #(.WIN_AW(PRG_WIN_AW)) u_prg (
        .upper_win (cpu_addr[PRG_WIN_AW]),
        .offset    (cpu_addr[PRG_WIN_AW-1:0]),
        .bank_sel  (prg_sel),
        .rom_addr  (prg_addr)
    );

    mapper_chr_map #(.WIN_AW(CHR_WIN_AW)) u_chr (
        .ppu_off     (ppu_addr),
        .bank_sel    (bank_q.chr),
        .mirror_vert (mirror_vert),
        .rom_addr    (chr_addr),
        .nt_a10      (ciram_a10)
    );
endmodule

// File: rtl/addr_latch_mapper_chk.sv
module addr_latch_mapper_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [12:0] ppu_addr,
    input logic        mirror_vert,
    input logic [15:0] prg_addr,
    input logic        prg_ce,
    input logic [14:0] chr_addr,
    input logic        ciram_a10,
    input logic [1:0]  prg_sel
);
    p_capture_prg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=> (prg_sel == $past(cpu_addr[3:2])));

    p_capture_chr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=> (chr_addr[14:13] == $past(cpu_addr[1:0])));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr[15]) |=> ($stable(prg_sel) && $stable(chr_addr[14:13])));

    p_lower_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[14] |-> (prg_addr == {prg_sel, cpu_addr[13:0]}));

    p_fixed_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[14] |-> (prg_addr == {2'b11, cpu_addr[13:0]}));

    p_ce_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_addr[15] || !cpu_rd) |-> !prg_ce);

    p_ce_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15] && cpu_rd) |-> prg_ce);

    p_chr_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[12:0] == ppu_addr);

    p_mirror_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mirror_vert |-> (ciram_a10 == ppu_addr[10]));

    p_mirror_h_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mirror_vert |-> (ciram_a10 == ppu_addr[11]));
endmodule

bind addr_latch_mapper addr_latch_mapper_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_rd      (cpu_rd),
    .cpu_wr      (cpu_wr),
    .ppu_addr    (ppu_addr),
    .mirror_vert (mirror_vert),
    .prg_addr    (prg_addr),
    .prg_ce      (prg_ce),
    .chr_addr    (chr_addr),
    .ciram_a10   (ciram_a10),
    .prg_sel     (prg_sel)
);

// File: tb/addr_latch_mapper_tb.sv
`timescale 1ns/1ps
module addr_latch_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic        mirror_vert = 1'b0;
    logic [15:0] prg_addr;
    logic        prg_ce;
    logic [14:0] chr_addr;
    logic        ciram_a10;

    int checks = 0;
    int failures = 0;
    int m_prg = 0;
    int m_chr = 0;

    always #2 clk = ~clk;

    addr_latch_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .mirror_vert(mirror_vert),
        .prg_addr(prg_addr), .prg_ce(prg_ce), .chr_addr(chr_addr),
        .ciram_a10(ciram_a10)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // one bus cycle: drive at the falling edge, compare against the model,
    // then advance the model for the coming rising edge
    task automatic step(input logic [15:0] a, input logic rd, input logic wr,
                        input logic [12:0] pa, input logic mv);
        int exp_hi;
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; ppu_addr = pa; mirror_vert = mv;
        #1;
        exp_hi = a[14] ? 3 : m_prg;
        if (a[14]) chk("R4 prg_addr", int'(prg_addr), (exp_hi << 14) | int'(a[13:0]));
        else       chk("R3 prg_addr", int'(prg_addr), (exp_hi << 14) | int'(a[13:0]));
        chk("R6 prg_ce", int'(prg_ce), int'(rd && a[15]));
        chk("R7 chr_addr", int'(chr_addr), (m_chr << 13) | int'(pa));
        chk("R8 ciram_a10", int'(ciram_a10), int'(mv ? pa[10] : pa[11]));
        if (rst_n && wr && a[15]) begin
            m_prg = int'(a[3:2]);
            m_chr = int'(a[1:0]);
        end
    endtask

    task automatic bank_probe(input string req, input int ep, input int ec);
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        chk({req, " prg bank"}, int'(prg_addr[15:14]), ep);
        chk({req, " chr bank"}, int'(chr_addr[14:13]), ec);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: writes during reset must not load the register
        for (int i = 0; i < 3; i++) step(16'hFFFF, 1'b1, 1'b1, 13'h1C00, 1'b1);
        bank_probe("R1 in reset", 0, 0);
        @(negedge clk); rst_n = 1'b1;
        bank_probe("R1 after reset", 0, 0);

        // R2: only A3..A0 are captured, upper bits are don't-care
        step(16'h800B, 1'b0, 1'b1, 13'h0000, 1'b0);
        bank_probe("R2 8000|B", 2, 3);
        step(16'hFFF4, 1'b0, 1'b1, 13'h0400, 1'b1);
        bank_probe("R2 FFF4", 1, 0);
        step(16'hC3A6, 1'b0, 1'b1, 13'h0800, 1'b0);
        bank_probe("R2 C3A6", 1, 2);

        // R5: writes to $6000 and other low addresses are ignored
        step(16'h6000, 1'b0, 1'b1, 13'h0000, 1'b0);
        bank_probe("R5 6000", 1, 2);
        step(16'h600F, 1'b0, 1'b1, 13'h0000, 1'b0);
        step(16'h7FF0, 1'b0, 1'b1, 13'h0000, 1'b0);
        step(16'h0005, 1'b0, 1'b1, 13'h0000, 1'b0);
        bank_probe("R5 low writes", 1, 2);

        // R4: the upper window stays at bank 3 for every register value
        for (int v = 0; v < 16; v++) begin
            step(16'h8000 | 16'(v), 1'b0, 1'b1, 13'h0000, 1'b0);
            step(16'hC000 | 16'(v * 97), 1'b1, 1'b0, 13'(v * 311), v[0]);
            step(16'h8000 | 16'(v * 131), 1'b1, 1'b0, 13'(v * 53), v[1]);
        end

        // random mix of reads, writes, strap values and addresses
        for (int n = 0; n < 600; n++) begin
            step(16'($urandom), 1'($urandom), ($urandom % 3) == 0,
                 13'($urandom), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule